// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into memory by walking a circular list of receive descriptors. Each descriptor is four consecutive 32-bit words at word offsets 0 to 3: status, control, buffer address and next-descriptor address. The engine reads all four words, and it fills a descriptor only if the status word grants ownership. It packs the frame's bytes into the descriptor's buffer, then writes back a status word that returns ownership to the host. The address of the next descriptor is always taken from the fetched next-descriptor word. The ring therefore closes by itself, and the block keeps no index counter.

Software writes the address of the first descriptor through the base-write strobe, and the engine starts fetching. When the engine meets a descriptor it does not own, it stops, pulses a buffer-unavailable output and holds the stream off. A poll-demand strobe makes it fetch that same descriptor again. A frame longer than its buffer continues in the following descriptor. Only the first descriptor of a frame carries the first flag, and only the final one carries the last flag, the error flags and the match flags.

The memory port is word addressed. It has single-cycle writes and reads whose data returns one cycle after the request.

Top module: `rxring_engine`

## Requirements
- R1: After reset the engine is idle: `inReady`, `memRe`, `memWe`, `doneIrq` and `bufUnavail` are low, and nothing is fetched until `baseWe` is pulsed.
- R2: A `baseWe` pulse while idle or suspended starts a fetch at `baseAddr`. The engine reads word offsets 0, 1, 2 and 3 on consecutive cycles, in that order.
- R3: While it owns a descriptor, the engine raises `inReady` and stores the accepted bytes little-endian (byte n of the buffer goes to bits 8*(n mod 4)+7 down to 8*(n mod 4) of word buffer+n/4). Lanes above the last byte of the final word are written as zero.
- R4: If status bit 31 of a fetched descriptor is 0, the engine suspends. It pulses `bufUnavail` for one cycle, keeps `inReady` low and writes nothing.
- R5: The write-back status word has bit 31 = 0. Bits 27:16 hold the frame's byte count up to the end of this descriptor, counting the CRC bytes as delivered. Bit 11 marks the frame's first descriptor and bit 10 its last. Bits 14, 13 and 12 copy `inMatch[2]`, `inMatch[1]` and `inMatch[0]` as sampled with `inEof`.
- R6: `inErr[4:0]` as sampled with `inEof` lands in status bits 6:2 (runt, long, alignment, CRC, receive error). Bit 7 is the OR of them. These bits are zero on a descriptor that is not the last of its frame.
- R7: Control bits 10:0 give the buffer size in bytes, with a size of at least 1 assumed. The engine never writes past it. A longer frame continues in the next descriptor with the first flag clear.
- R8: If control bit 23 is set, `doneIrq` pulses for one cycle in the cycle after that descriptor's status write.
- R9: After write-back, the next descriptor fetched is the one at the address in word 3, so the ring wraps to its head.
- R10: A `pollDemand` pulse while suspended fetches the same descriptor again. If it is still not owned, `bufUnavail` pulses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWe | input | 1 | Load start descriptor address and begin fetching |
| baseAddr | input | ADDR_W | Word address of the first descriptor |
| pollDemand | input | 1 | Retry a descriptor that was not owned |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| inErr | input | 5 | Frame error flags, valid with inEof |
| inMatch | input | 3 | Address match kind, valid with inEof |
| inReady | output | 1 | Engine accepts a byte this cycle |
| memRe | output | 1 | Memory read request |
| memWe | output | 1 | Memory write request |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Read data, one cycle after memRe |
| doneIrq | output | 1 | Completion interrupt pulse |
| bufUnavail | output | 1 | Suspended on a descriptor it does not own |

## Verification
The assertions assume the following of the inputs:
- Frames are well formed: `inSof` is on the first byte and `inEof` on the last.
- Every buffer size is at least 1.
- No buffer overlaps a descriptor.
- Read data arrives exactly one cycle after the request.

The bench keeps within these by building every descriptor itself. Buffers sit in a region apart from the descriptors and always have a non-zero size. Every frame is driven from a task that places the frame flags correctly. A single-cycle memory model answers the read requests.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  localparam int OWN_BIT   = 31;
  localparam int LEN_LSB   = 16;
  localparam int MATCH_LSB = 12;
  localparam int FIRST_BIT = 11;
  localparam int LAST_BIT  = 10;
  localparam int SUM_BIT   = 7;
  localparam int ERR_LSB   = 2;
  localparam int IRQ_BIT   = 23;
  localparam int ERR_W     = 5;
  localparam int MATCH_W   = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_CHK, ST_RECV, ST_WB, ST_SUSP
  } ringState_t;

  typedef struct packed {
    logic       rdEn;
    logic [1:0] rdOff;
    logic       capStatus;
    logic       capCtrl;
    logic       capBuf;
    logic       capNext;
    logic       openDesc;
    logic       recvOn;
    logic       wrStatus;
    logic       advance;
    logic       loadBase;
  } dpCtl_t;

endpackage

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter int BSZ_W  = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic                inValid,
  input  logic [7:0]          inData,
  input  logic                inSof,
  input  logic                inEof,
  input  logic [ERR_W-1:0]    inErr,
  input  logic [MATCH_W-1:0]  inMatch,
  input  logic [31:0]         memRdata,
  output logic                memRe,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [31:0]         memWdata,
  output logic                descOwned,
  output logic                irqReq,
  output logic                frameEndTake,
  output logic                bufEndTake
);

  localparam int CNT_W = BSZ_W + 1;

  logic [ADDR_W-1:0]  curDesc, nextPtr, bufPtr;
  logic [BSZ_W-1:0]   bufSize, bufCnt;
  logic [LEN_W-1:0]   frameLen;
  logic               inFrame, firstDesc, lastDesc;
  logic [ERR_W-1:0]   errReg;
  logic [MATCH_W-1:0] matchReg;
  logic [31:0]        wordAcc;

  logic               accept, bufLast, wordWrite;
  logic [1:0]         lane;
  logic [31:0]        laneWord, nextWord, statusWord;
  logic [ADDR_W-1:0]  dataAddr;
  logic               unusedRd;

  assign unusedRd = ^memRdata;

  assign accept    = ctl.recvOn & inValid;
  assign lane      = bufCnt[1:0];
  assign laneWord  = {24'b0, inData} << {lane, 3'b000};
  assign nextWord  = wordAcc | laneWord;
  assign bufLast   = ({1'b0, bufCnt} + CNT_W'(1)) == {1'b0, bufSize};
  assign wordWrite = accept & ((lane == 2'd3) | inEof | bufLast);
  assign dataAddr  = bufPtr + ADDR_W'(bufCnt >> 2);

  assign frameEndTake = accept & inEof;
  assign bufEndTake   = accept & bufLast;

  always_comb begin
    statusWord = '0;
    statusWord[LEN_LSB +: LEN_W]     = frameLen;
    statusWord[MATCH_LSB +: MATCH_W] = matchReg;
    statusWord[FIRST_BIT]            = firstDesc;
    statusWord[LAST_BIT]             = lastDesc;
    statusWord[SUM_BIT]              = |errReg;
    statusWord[ERR_LSB +: ERR_W]     = errReg;
  end

  assign memRe = ctl.rdEn;
  assign memWe = ctl.wrStatus | wordWrite;

  always_comb begin
    if (ctl.wrStatus) begin
      memAddr  = curDesc;
      memWdata = statusWord;
    end else if (wordWrite) begin
      memAddr  = dataAddr;
      memWdata = nextWord;
    end else begin
      memAddr  = curDesc + ADDR_W'(ctl.rdOff);
      memWdata = nextWord;
    end
  end

  // descriptor fields and ring pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDesc   <= '0;
      nextPtr   <= '0;
      bufPtr    <= '0;
      bufSize   <= '0;
      irqReq    <= 1'b0;
      descOwned <= 1'b0;
    end else begin
      if (ctl.loadBase) curDesc <= baseAddr;
      else if (ctl.advance) curDesc <= nextPtr;
      if (ctl.capStatus) descOwned <= memRdata[OWN_BIT];
      if (ctl.capCtrl) begin
        bufSize <= memRdata[BSZ_W-1:0];
        irqReq  <= memRdata[IRQ_BIT];
      end
      if (ctl.capBuf)  bufPtr  <= memRdata[ADDR_W-1:0];
      if (ctl.capNext) nextPtr <= memRdata[ADDR_W-1:0];
    end
  end

  // frame bookkeeping and byte packing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufCnt    <= '0;
      frameLen  <= '0;
      inFrame   <= 1'b0;
      firstDesc <= 1'b0;
      lastDesc  <= 1'b0;
      errReg    <= '0;
      matchReg  <= '0;
      wordAcc   <= '0;
    end else if (ctl.openDesc) begin
      bufCnt    <= '0;
      firstDesc <= !inFrame;
      lastDesc  <= 1'b0;
      errReg    <= '0;
      matchReg  <= '0;
      wordAcc   <= '0;
    end else if (accept) begin
      bufCnt   <= bufCnt + BSZ_W'(1);
      frameLen <= inSof ? LEN_W'(1) : frameLen + LEN_W'(1);
      inFrame  <= !inEof;
      wordAcc  <= wordWrite ? 32'b0 : nextWord;
      if (inEof) begin
        lastDesc <= 1'b1;
        errReg   <= inErr;
        matchReg <= inMatch;
      end
    end
  end

  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !ctl.wrStatus) |-> (bufCnt < bufSize));

  assert_err_on_last_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrStatus && !memWdata[LAST_BIT]) |-> (memWdata[SUM_BIT:ERR_LSB] == '0));

endmodule

// File: rtl/rxring_ctl.sv
module rxring_ctl
  import rxring_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   baseWe,
  input  logic   pollDemand,
  input  logic   descOwned,
  input  logic   irqReq,
  input  logic   frameEndTake,
  input  logic   bufEndTake,
  output dpCtl_t ctl,
  output logic   doneIrq,
  output logic   bufUnavail
);

  ringState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (baseWe) begin
        ctl.loadBase = 1'b1;
        stateNext    = ST_RD0;
      end
      ST_RD0: begin
        ctl.rdEn  = 1'b1;
        ctl.rdOff = 2'd0;
        stateNext = ST_RD1;
      end
      ST_RD1: begin
        ctl.rdEn      = 1'b1;
        ctl.rdOff     = 2'd1;
        ctl.capStatus = 1'b1;
        stateNext     = ST_RD2;
      end
      ST_RD2: begin
        ctl.rdEn    = 1'b1;
        ctl.rdOff   = 2'd2;
        ctl.capCtrl = 1'b1;
        stateNext   = ST_RD3;
      end
      ST_RD3: begin
        ctl.rdEn   = 1'b1;
        ctl.rdOff  = 2'd3;
        ctl.capBuf = 1'b1;
        stateNext  = ST_CHK;
      end
      ST_CHK: begin
        ctl.capNext = 1'b1;
        if (descOwned) begin
          ctl.openDesc = 1'b1;
          stateNext    = ST_RECV;
        end else begin
          stateNext = ST_SUSP;
        end
      end
      ST_RECV: begin
        ctl.recvOn = 1'b1;
        if (frameEndTake || bufEndTake) stateNext = ST_WB;
      end
      ST_WB: begin
        ctl.wrStatus = 1'b1;
        ctl.advance  = 1'b1;
        stateNext    = ST_RD0;
      end
      ST_SUSP: begin
        if (baseWe) begin
          ctl.loadBase = 1'b1;
          stateNext    = ST_RD0;
        end else if (pollDemand) begin
          stateNext = ST_RD0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      doneIrq    <= 1'b0;
      bufUnavail <= 1'b0;
    end else begin
      state      <= stateNext;
      doneIrq    <= ctl.wrStatus & irqReq;
      bufUnavail <= (state == ST_CHK) & !descOwned;
    end
  end

  assert_poll_restarts_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && pollDemand) |=> ctl.rdEn);

  assert_recv_after_fetch_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.recvOn) |-> $past(ctl.rdEn, 2));

endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter int BSZ_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              pollDemand,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [4:0]        inErr,
  input  logic [2:0]        inMatch,
  output logic              inReady,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              doneIrq,
  output logic              bufUnavail
);

  dpCtl_t ctl;
  logic   descOwned, irqReq, frameEndTake, bufEndTake;

  rxring_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .baseWe       (baseWe),
    .pollDemand   (pollDemand),
    .descOwned    (descOwned),
    .irqReq       (irqReq),
    .frameEndTake (frameEndTake),
    .bufEndTake   (bufEndTake),
    .ctl          (ctl),
    .doneIrq      (doneIrq),
    .bufUnavail   (bufUnavail)
  );

  rxring_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BSZ_W(BSZ_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .baseAddr     (baseAddr),
    .inValid      (inValid),
    .inData       (inData),
    .inSof        (inSof),
    .inEof        (inEof),
    .inErr        (inErr),
    .inMatch      (inMatch),
    .memRdata     (memRdata),
    .memRe        (memRe),
    .memWe        (memWe),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .descOwned    (descOwned),
    .irqReq       (irqReq),
    .frameEndTake (frameEndTake),
    .bufEndTake   (bufEndTake)
  );

  assign inReady = ctl.recvOn;

  assert_suspend_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    bufUnavail |-> (!inReady && !memWe));

  assert_irq_follows_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> $past(memWe));

endmodule

// File: tb/rxring_engine_bench.sv
`timescale 1ns/1ps
module rxring_engine_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWe = 1'b0;
  logic [15:0] baseAddr = '0;
  logic        pollDemand = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inSof = 1'b0, inEof = 1'b0;
  logic [4:0]  inErr = '0;
  logic [2:0]  inMatch = '0;
  logic        inReady, memRe, memWe, doneIrq, bufUnavail;
  logic [15:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  logic        hostWe = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostData = '0;
  logic [31:0] mem [0:255];

  int checks = 0, errors = 0;
  int irqCnt = 0, unavailCnt = 0, wrCnt = 0, rdCount = 0;
  logic [15:0] rdLog [0:3];

  always #2 clk = ~clk;

  rxring_engine u_rxring_engine (
    .clk(clk), .rstN(rstN), .baseWe(baseWe), .baseAddr(baseAddr),
    .pollDemand(pollDemand), .inValid(inValid), .inData(inData),
    .inSof(inSof), .inEof(inEof), .inErr(inErr), .inMatch(inMatch),
    .inReady(inReady), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .doneIrq(doneIrq),
    .bufUnavail(bufUnavail)
  );

  always @(posedge clk) begin
    if (memRe) memRdata <= mem[memAddr[7:0]];
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    if (hostWe) mem[hostAddr] <= hostData;
  end

  always @(negedge clk) begin
    if (doneIrq) irqCnt++;
    if (bufUnavail) unavailCnt++;
    if (memWe) wrCnt++;
    if (memRe) begin
      if (rdCount < 4) rdLog[rdCount] = memAddr;
      rdCount++;
    end
  end

  // frame table: length, error flags, match flags, expected status word
  localparam int          N_FR = 4;
  localparam int          FR_LEN   [N_FR] = '{6, 9, 64, 3};
  localparam logic [4:0]  FR_ERR   [N_FR] = '{5'b00000, 5'b00010, 5'b00000, 5'b10000};
  localparam logic [2:0]  FR_MATCH [N_FR] = '{3'b001, 3'b010, 3'b100, 3'b000};
  localparam logic [31:0] FR_EXP   [N_FR] = '{32'h00061C00, 32'h00092C88,
                                              32'h00404C00, 32'h00030CC0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic setDesc(input int k, input bit own, input int size, input bit irq);
    logic [7:0] d;
    d = 8'(8'h10 + 4 * k);
    hostWrite(d,      {own, 31'b0});
    hostWrite(d + 1,  32'(size) | (32'(irq) << 23));
    hostWrite(d + 2,  32'(8'h40 + 16 * k));
    hostWrite(d + 3,  32'(8'h10 + 4 * ((k + 1) % 4)));
  endtask

  task automatic sendFrame(input logic [7:0] seed, input int len,
                           input logic [4:0] err, input logic [2:0] match);
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      inValid = 1'b1; inData = seed + 8'(n);
      inSof = (n == 0); inEof = (n == len - 1);
      inErr = err; inMatch = match;
      while (!inReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  // bytes [first, first+count) of a frame stored from buffer byte 0
  task automatic checkData(input string tag, input logic [7:0] buf0,
                           input logic [7:0] seed, input int first, input int count);
    for (int j = 0; j < (count + 3) / 4; j++) begin
      logic [31:0] w;
      w = '0;
      for (int b = 0; b < 4; b++)
        if (4 * j + b < count) w[8*b +: 8] = seed + 8'(first + 4 * j + b);
      check(tag, mem[buf0 + 8'(j)], w);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(4);
    // R1: reset state
    check("R1 inReady", 32'(inReady), 0);
    check("R1 mem access", 32'(memRe | memWe), 0);
    check("R1 pulses", 32'(doneIrq | bufUnavail), 0);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) setDesc(k, 1'b1, 64, (k % 2) == 0);
    check("R1 idle no fetch", 32'(rdCount), 0);

    @(negedge clk); baseWe = 1'b1; baseAddr = 16'h0010;
    @(negedge clk); baseWe = 1'b0;
    waitCyc(6);
    for (int i = 0; i < 4; i++) check("R2 fetch order", 32'(rdLog[i]), 32'(16'h10 + i));

    // R3 R5 R6: table of frames walked around the ring
    for (int k = 0; k < N_FR; k++) begin
      sendFrame(8'(8'h05 + 8'h21 * k), FR_LEN[k], FR_ERR[k], FR_MATCH[k]);
      waitCyc(8);
      check("R5 R6 status", mem[8'(8'h10 + 4 * k)], FR_EXP[k]);
      checkData("R3 data", 8'(8'h40 + 16 * k), 8'(8'h05 + 8'h21 * k), 0, FR_LEN[k]);
    end
    check("R8 irq count", 32'(irqCnt), 2);
    check("R4 R9 wrapped to unowned head", 32'(unavailCnt), 1);

    // R4: stream held off while suspended
    begin
      int w0;
      w0 = wrCnt;
      @(negedge clk); inValid = 1'b1; inData = 8'hAA; inSof = 1'b1; inEof = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check("R4 ready low while suspended", 32'(inReady), 0);
      end
      inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
      check("R4 no writes while suspended", 32'(wrCnt), 32'(w0));
    end

    // R10: poll with head still not owned
    @(negedge clk); pollDemand = 1'b1;
    @(negedge clk); pollDemand = 1'b0;
    waitCyc(8);
    check("R10 repoll unowned", 32'(unavailCnt), 2);

    // refill: head owned, next small buffer for spill, sentinel after it
    setDesc(0, 1'b1, 64, 1'b1);
    setDesc(1, 1'b1, 5, 1'b0);
    setDesc(2, 1'b1, 64, 1'b0);
    hostWrite(8'h52, 32'hDEADBEEF);
    @(negedge clk); pollDemand = 1'b1;
    @(negedge clk); pollDemand = 1'b0;

    sendFrame(8'h70, 7, 5'b00001, 3'b000);
    waitCyc(8);
    check("R9 R10 head reused status", mem[8'h10], 32'h00070C84);
    checkData("R9 head data", 8'h40, 8'h70, 0, 7);
    check("R8 irq on head", 32'(irqCnt), 3);

    // R7: spill across two descriptors
    sendFrame(8'h90, 8, 5'b01000, 3'b011);
    waitCyc(10);
    check("R7 spill first part", mem[8'h14], 32'h00050800);
    check("R7 R6 spill last part", mem[8'h18], 32'h000834A0);
    checkData("R7 spill data a", 8'h50, 8'h90, 0, 5);
    checkData("R7 spill data b", 8'h60, 8'h90, 5, 3);
    check("R7 no write past buffer", mem[8'h52], 32'hDEADBEEF);
    check("R8 no irq without bit", 32'(irqCnt), 3);
    check("R4 suspend after spill", 32'(unavailCnt), 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule